// File: doc/BRIEF.md
# Retired-Instruction Countdown Trigger

This block is a debug trigger that counts down retired instructions. Software loads a control word. The word holds a remaining-count field and a set of privilege-mode enable bits. Each instruction the hart retires in an enabled mode lowers the count by one. The retire that brings the count from one to zero raises a single-cycle fire pulse, which the core takes as a breakpoint request.

A count of zero leaves the trigger idle. Retires in a mode whose enable bit is clear are discarded and leave the count where it was. Reading the control word always shows the live remaining count. The type code 3 sits in the top nibble of the word. The trigger has no compare register, so a write to the second data register is accepted and changes nothing.

Top module: `instr_count_trigger`

## Requirements
- R1: After reset the control word reads 0x3000_0000 (type code 3 in bits 31:28, everything else zero) and fire is low.
- R2: A control write keeps only the count field (bits 23:10) and the mode enables (bits 6, 7, 9, 25, 26). Every other bit reads zero, and bits 31:28 always read 3 whatever was written.
- R3: A retire in an enabled mode with a nonzero count lowers the count by one, and the change is visible on the next cycle.
- R4: When not virtualized, privilege 0 (U) is enabled by bit 6, privilege 1 (S) by bit 7 and privilege 3 (M) by bit 9. Privilege 2 is never enabled.
- R5: While virtualized, privilege 0 (VU) is enabled by bit 25 and privilege 1 (VS) by bit 26. The U/S/M bits are ignored, and privileges 2 and 3 are never enabled.
- R6: A retire in a mode that is not enabled leaves the count unchanged and does not fire.
- R7: A count of zero never decrements and never fires.
- R8: Fire is high, combinationally and in the same cycle, for an enabled retire that finds the count at one. It lasts a single cycle, and the count then reads zero.
- R9: A write to the second data register has no effect on the control word.
- R10: A control write in the same cycle as a retire loads the written value, ignores the retire and does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire | input | 1 | One instruction retired this cycle |
| priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| virt | input | 1 | Hart runs virtualized |
| csr_wr_ctrl | input | 1 | Write strobe for the control word |
| csr_wr_cmp | input | 1 | Write strobe for the second data register |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Control word with live count |
| fire | output | 1 | Breakpoint request pulse |

## Verification
The assertions assume that at most one instruction retires per cycle. They also assume that the privilege and virtualization inputs are stable and valid in the cycle of a retire. The bench holds to this: it drives at most one retire per cycle and changes every input only at the falling edge. Privilege 2 is driven on purpose as a mode that can never be enabled. Write strobes are driven alone or together with a single retire, and never together with each other.

// File: rtl/instr_count_trigger.sv
module instr_count_trigger #(
  parameter int XLEN      = 32,
  parameter int CNT_LSB   = 10,
  parameter int CNT_W     = 14,
  parameter int NATIVE_EN = 6,
  parameter int GUEST_EN  = 25,
  parameter int TYPE_CODE = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic            csr_wr_ctrl,
  input  logic            csr_wr_cmp,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            fire
);
  localparam int TYPE_LSB = XLEN - 4;
  localparam logic [XLEN-1:0] ONE = XLEN'(1);
  localparam logic [XLEN-1:0] CNT_MASK  = XLEN'((1 << CNT_W) - 1) << CNT_LSB;
  localparam logic [XLEN-1:0] MODE_MASK = (ONE << NATIVE_EN) | (ONE << (NATIVE_EN + 1)) |
                                          (ONE << (NATIVE_EN + 3)) | (ONE << GUEST_EN) |
                                          (ONE << (GUEST_EN + 1));
  localparam logic [XLEN-1:0] KEEP_MASK = CNT_MASK | MODE_MASK;
  localparam logic [XLEN-1:0] TYPE_WORD = XLEN'(TYPE_CODE) << TYPE_LSB;

  logic [XLEN-1:0]  ctrl_q;
  logic [CNT_W-1:0] cnt;
  logic             mode_ok, step;

  assign cnt = ctrl_q[CNT_LSB +: CNT_W];

  always_comb begin
    if (virt)
      mode_ok = !priv[1] && ctrl_q[GUEST_EN + int'(priv[0])];
    else
      mode_ok = (priv != 2'd2) && ctrl_q[NATIVE_EN + int'(priv)];
  end

  assign step      = retire && mode_ok && (cnt != '0) && !csr_wr_ctrl;
  assign fire      = step && (cnt == CNT_W'(1));
  assign csr_rdata = ctrl_q | TYPE_WORD;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (csr_wr_ctrl)
      ctrl_q <= csr_wdata & KEEP_MASK;
    else if (step)
      ctrl_q[CNT_LSB +: CNT_W] <= cnt - CNT_W'(1);
  end

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && mode_ok && cnt != '0 && !csr_wr_ctrl) |=>
      csr_rdata[CNT_LSB +: CNT_W] == $past(csr_rdata[CNT_LSB +: CNT_W]) - CNT_W'(1));

  // R6
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !mode_ok && !csr_wr_ctrl) |=> $stable(csr_rdata));

  // R7
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !csr_wr_ctrl) |=> (cnt == '0 && !fire));

  // R8
  fire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (!fire && csr_rdata[CNT_LSB +: CNT_W] == '0));

  // R9
  cmp_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_cmp && !csr_wr_ctrl && !retire) |=> $stable(csr_rdata));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr_ctrl |-> !fire);

  // R2
  type_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[XLEN-1:TYPE_LSB] == 4'(TYPE_CODE));
endmodule

// File: tb/tb_instr_count_trigger.sv
module tb_instr_count_trigger;
  localparam int CLK_P = 10;
  localparam logic [31:0] TYPEW = 32'h3000_0000;
  localparam logic [31:0] B_U = 32'h40, B_S = 32'h80, B_M = 32'h200;
  localparam logic [31:0] B_VU = 32'h0200_0000, B_VS = 32'h0400_0000;

  logic clk = 0, rst_n = 0, retire = 0, virt = 0, csr_wr_ctrl = 0, csr_wr_cmp = 0;
  logic [1:0] priv = 2'd3;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic fire;
  int checks = 0, fails = 0;
  logic f;

  instr_count_trigger dut (.clk, .rst_n, .retire, .priv, .virt, .csr_wr_ctrl,
                           .csr_wr_cmp, .csr_wdata, .csr_rdata, .fire);

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] word(input logic [31:0] modes, input int cnt);
    return TYPEW | modes | (32'(cnt) << 10);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic ret, input logic [1:0] p, input logic v,
                      input logic wc, input logic wd, input logic [31:0] dat,
                      output logic fo);
    @(negedge clk);
    retire = ret; priv = p; virt = v; csr_wr_ctrl = wc; csr_wr_cmp = wd; csr_wdata = dat;
    #1 fo = fire;
    @(posedge clk); #1;
    retire = 0; csr_wr_ctrl = 0; csr_wr_cmp = 0;
  endtask

  task automatic wr(input logic [31:0] dat);
    step(0, 2'd3, 0, 1, 0, dat, f);
  endtask

  task automatic t_reset;
    chk("R1 rdata", csr_rdata, TYPEW);
    chk("R1 fire", 32'(fire), 0);
  endtask

  task automatic t_mask;
    wr(32'hFFFF_FFFF);
    chk("R2 all-ones", csr_rdata, word(B_U|B_S|B_M|B_VU|B_VS, 16'h3FFF));
    wr(32'h0000_0100);
    chk("R2 reserved bit", csr_rdata, TYPEW);
  endtask

  task automatic t_native;
    wr(word(B_U|B_S|B_M, 5));
    step(1, 2'd3, 0, 0, 0, 0, f); step(1, 2'd3, 0, 0, 0, 0, f);
    chk("R3 two M retires", csr_rdata, word(B_U|B_S|B_M, 3));
    step(1, 2'd0, 0, 0, 0, 0, f);
    chk("R4 U retire", csr_rdata, word(B_U|B_S|B_M, 2));
    step(1, 2'd1, 0, 0, 0, 0, f);
    chk("R4 S retire", csr_rdata, word(B_U|B_S|B_M, 1));
    step(1, 2'd2, 0, 0, 0, 0, f);
    chk("R4 priv2 never", csr_rdata, word(B_U|B_S|B_M, 1));
    chk("R6 no fire priv2", 32'(f), 0);
    step(1, 2'd3, 0, 0, 0, 0, f);
    chk("R8 fire same cycle", 32'(f), 1);
    chk("R8 count zero", csr_rdata, word(B_U|B_S|B_M, 0));
    #1 chk("R8 single pulse", 32'(fire), 0);
    step(1, 2'd3, 0, 0, 0, 0, f);
    chk("R7 zero no fire", 32'(f), 0);
    chk("R7 zero hold", csr_rdata, word(B_U|B_S|B_M, 0));
  endtask

  task automatic t_virt;
    wr(word(B_U|B_S|B_M, 3));
    step(1, 2'd0, 1, 0, 0, 0, f);
    chk("R5 U bit ignored virt", csr_rdata, word(B_U|B_S|B_M, 3));
    wr(word(B_VU, 3));
    step(1, 2'd0, 1, 0, 0, 0, f);
    chk("R5 VU retire", csr_rdata, word(B_VU, 2));
    step(1, 2'd1, 1, 0, 0, 0, f);
    chk("R6 VS disabled", csr_rdata, word(B_VU, 2));
    step(1, 2'd0, 0, 0, 0, 0, f);
    chk("R6 U disabled native", csr_rdata, word(B_VU, 2));
    wr(word(B_VS|B_M, 2));
    step(1, 2'd3, 1, 0, 0, 0, f);
    chk("R5 priv3 virt never", csr_rdata, word(B_VS|B_M, 2));
    step(1, 2'd1, 1, 0, 0, 0, f);
    chk("R5 VS retire", csr_rdata, word(B_VS|B_M, 1));
  endtask

  task automatic t_cmp;
    step(0, 2'd3, 0, 0, 1, 32'hFFFF_FFFF, f);
    chk("R9 cmp write ignored", csr_rdata, word(B_VS|B_M, 1));
  endtask

  task automatic t_collide;
    step(1, 2'd3, 0, 1, 0, word(B_M, 1), f);
    chk("R10 no fire on write", 32'(f), 0);
    chk("R10 written value", csr_rdata, word(B_M, 1));
    step(1, 2'd3, 0, 0, 0, 0, f);
    chk("R10 next retire fires", 32'(f), 1);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    t_reset;
    t_mask;
    t_native;
    t_virt;
    t_cmp;
    t_collide;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule